// File: doc/BRIEF.md
# Wide Immediate Instruction Assembler

This block sits on a stream of 64-bit instruction slots that arrive with a valid/ready handshake. Most slots pass straight through as single-slot records. A slot whose opcode is the wide immediate-load opcode is the first half of a two-slot instruction. The block keeps that slot's destination register, subtype and low immediate, then takes the next slot as its companion pseudo slot. It emits one assembled record that carries the destination, the subtype, the low immediate and the companion's immediate. For the plain integer subtype the record also carries the joined 64-bit value.

The block checks each companion slot, each subtype and the stream boundary. A companion slot whose low 32 bits are not all zero is flagged as malformed. A subtype outside the defined range is flagged as illegal. An end-of-stream marker that arrives while the companion is still awaited closes the pair with a truncation record. The block does not resolve any handles or addresses that a subtype refers to. It only forwards the two immediates.

Top module: `wide_imm_assembler`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A non-marker slot accepted while no pair is open, with opcode (bits [7:0]) not equal to 0x18, is emitted once with `out_kind`=0, `out_slot` equal to the input slot, and all other output fields and flags zero.
- R3: A non-marker slot with opcode 0x18 accepted while no pair is open produces no record. The block then keeps `in_ready` at 1 and `out_valid` at 0 until the next beat.
- R4: When a pair closes with subtype 0, the record has `out_kind`=1, `out_dst`=bits [11:8] and `out_sub`=bits [15:12] of the first slot, and `out_imm_lo`=bits [63:32] of the first slot. It also has `out_imm_hi`=bits [63:32] of the companion, and `out_value`={`out_imm_hi`,`out_imm_lo`}.
- R5: When a pair closes with subtype 1 to 15, `out_imm_hi` still carries the companion immediate and `out_value` is 0.
- R6: `out_err_pseudo` is 1 exactly when the companion slot has any nonzero bit in [31:0], which covers its opcode, both register fields and its offset.
- R7: `out_err_sub` is 1 on a pair record exactly when the subtype is above 6. The record is still emitted.
- R8: A marker beat (`in_eos`=1, slot ignored) closes an open pair with a record that has `out_err_trunc`=1, the first slot's fields, and `out_imm_hi`=`out_value`=0. A marker beat with no pair open produces no record.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value. `in_ready` is 0 whenever `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_slot | input | 64 | Instruction slot |
| in_eos | input | 1 | Beat is an end-of-stream marker; slot ignored |
| in_ready | output | 1 | Block accepts a beat |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Consumer takes the record |
| out_kind | output | 1 | 0 single slot, 1 assembled pair |
| out_slot | output | 64 | Forwarded slot (single-slot records) |
| out_dst | output | 4 | Destination register of the pair |
| out_sub | output | 4 | Subtype of the pair |
| out_imm_lo | output | 32 | First slot immediate |
| out_imm_hi | output | 32 | Companion immediate |
| out_value | output | 64 | Joined value for subtype 0, else 0 |
| out_err_pseudo | output | 1 | Companion slot malformed |
| out_err_sub | output | 1 | Subtype above 6 |
| out_err_trunc | output | 1 | Stream ended before the companion |

## Verification
The bench targets these error paths:
- Companion slots with a single nonzero bit in each low field. A design that checked only the opcode would let a stray register or offset through unflagged.
- The subtype boundary at 6/7 and at 15. An off-by-one there would flag subtype 6 or accept 7.
- Markers both inside an open pair and in the idle state. A design that dropped the truncation record would lose the first slot silently, and one that reacted to idle markers would emit phantom records.

It also checks two handshake behaviours:
- Random backpressure checks that a stalled record holds every field.
- A slot with opcode 0x18 appearing as the companion must be treated as data. A design that re-opened a pair there would swallow the following slot.

// File: rtl/wimm_pkg.sv
package wimm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE       = 2'd0,
      ST_HAVE_FIRST = 2'd1,
      ST_EMIT       = 2'd2
   } wimm_state_e;

   localparam int DEF_OPC_W  = 8;
   localparam int DEF_REG_W  = 4;
   localparam int DEF_OFF_W  = 16;
   localparam int DEF_IMM_W  = 32;
   localparam int DEF_SLOT_W = 64;
endpackage

// File: rtl/wimm_slot_split.sv
module wimm_slot_split #(
   parameter int OPC_W  = 8,
   parameter int REG_W  = 4,
   parameter int OFF_W  = 16,
   parameter int IMM_W  = 32,
   parameter int SLOT_W = 64
) (
   input  logic [SLOT_W-1:0] slot,
   output logic [OPC_W-1:0]  opc,
   output logic [REG_W-1:0]  dst,
   output logic [REG_W-1:0]  src,
   output logic [IMM_W-1:0]  imm,
   output logic              low_zero
);
   localparam int DST_LSB = OPC_W;
   localparam int SRC_LSB = DST_LSB + REG_W;
   localparam int OFF_LSB = SRC_LSB + REG_W;
   localparam int IMM_LSB = OFF_LSB + OFF_W;

   if (IMM_LSB + IMM_W != SLOT_W) begin : g_bad_layout
      $error("slot fields do not fill the slot width");
   end

   assign opc      = slot[DST_LSB-1:0];
   assign dst      = slot[SRC_LSB-1:DST_LSB];
   assign src      = slot[OFF_LSB-1:SRC_LSB];
   assign imm      = slot[SLOT_W-1:IMM_LSB];
   assign low_zero = (slot[IMM_LSB-1:0] == '0);
endmodule

// File: rtl/wimm_combine.sv
module wimm_combine #(
   parameter int IMM_W       = 32,
   parameter int SUB_W       = 4,
   parameter int MAX_SUB     = 6,
   parameter bit ZERO_NONINT = 1'b1
) (
   input  logic [SUB_W-1:0]   sub,
   input  logic [IMM_W-1:0]   lo,
   input  logic [IMM_W-1:0]   hi,
   output logic [2*IMM_W-1:0] value,
   output logic               sub_bad
);
   if (MAX_SUB >= (1 << SUB_W)) begin : g_bad_max
      $error("MAX_SUB does not fit the subtype field");
   end

   assign sub_bad = (sub > SUB_W'(MAX_SUB));

   if (ZERO_NONINT) begin : g_int_only
      assign value = (sub == '0) ? {hi, lo} : '0;
   end else begin : g_always_join
      assign value = {hi, lo};
   end
endmodule

// File: rtl/wide_imm_assembler.sv
module wide_imm_assembler
   import wimm_pkg::*;
#(
   parameter int              OPC_W       = DEF_OPC_W,
   parameter int              REG_W       = DEF_REG_W,
   parameter int              OFF_W       = DEF_OFF_W,
   parameter int              IMM_W       = DEF_IMM_W,
   parameter int              SLOT_W      = DEF_SLOT_W,
   parameter logic [OPC_W-1:0] WIDE_OPC   = 'h18,
   parameter int              MAX_SUB     = 6,
   parameter bit              ZERO_NONINT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [SLOT_W-1:0]  in_slot,
   input  logic               in_eos,
   output logic               in_ready,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               out_kind,
   output logic [SLOT_W-1:0]  out_slot,
   output logic [REG_W-1:0]   out_dst,
   output logic [REG_W-1:0]   out_sub,
   output logic [IMM_W-1:0]   out_imm_lo,
   output logic [IMM_W-1:0]   out_imm_hi,
   output logic [2*IMM_W-1:0] out_value,
   output logic               out_err_pseudo,
   output logic               out_err_sub,
   output logic               out_err_trunc
);
   localparam int VAL_W = 2 * IMM_W;

   if (OPC_W < 1 || REG_W < 1 || IMM_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   typedef struct packed {
      logic              kind;
      logic [SLOT_W-1:0] slot;
      logic [REG_W-1:0]  dst;
      logic [REG_W-1:0]  sub;
      logic [IMM_W-1:0]  lo;
      logic [IMM_W-1:0]  hi;
      logic [VAL_W-1:0]  value;
      logic              e_pseudo;
      logic              e_sub;
      logic              e_trunc;
   } rec_t;

   wimm_state_e       state, state_nxt;
   rec_t              rec_q, rec_nxt;
   logic              rec_load, hold_load, accept;
   logic [REG_W-1:0]  hold_dst, hold_sub;
   logic [IMM_W-1:0]  hold_lo;

   logic [OPC_W-1:0]  f_opc;
   logic [REG_W-1:0]  f_dst, f_src;
   logic [IMM_W-1:0]  f_imm;
   logic              f_low_zero;
   logic [VAL_W-1:0]  c_value;
   logic              c_sub_bad;

   wimm_slot_split #(
      .OPC_W(OPC_W), .REG_W(REG_W), .OFF_W(OFF_W),
      .IMM_W(IMM_W), .SLOT_W(SLOT_W)
   ) u_split (
      .slot(in_slot), .opc(f_opc), .dst(f_dst), .src(f_src),
      .imm(f_imm), .low_zero(f_low_zero)
   );

   wimm_combine #(
      .IMM_W(IMM_W), .SUB_W(REG_W), .MAX_SUB(MAX_SUB), .ZERO_NONINT(ZERO_NONINT)
   ) u_combine (
      .sub(hold_sub), .lo(hold_lo), .hi(f_imm),
      .value(c_value), .sub_bad(c_sub_bad)
   );

   assign in_ready = (state != ST_EMIT);
   assign accept   = in_valid && in_ready;

   always_comb begin
      state_nxt = state;
      rec_nxt   = '0;
      rec_load  = 1'b0;
      hold_load = 1'b0;
      case (state)
         ST_IDLE: begin
            if (accept && !in_eos) begin
               if (f_opc == WIDE_OPC) begin
                  hold_load = 1'b1;
                  state_nxt = ST_HAVE_FIRST;
               end else begin
                  rec_load     = 1'b1;
                  rec_nxt.slot = in_slot;
                  state_nxt    = ST_EMIT;
               end
            end
         end
         ST_HAVE_FIRST: begin
            if (accept) begin
               rec_load      = 1'b1;
               rec_nxt.kind  = 1'b1;
               rec_nxt.dst   = hold_dst;
               rec_nxt.sub   = hold_sub;
               rec_nxt.lo    = hold_lo;
               rec_nxt.e_sub = c_sub_bad;
               if (in_eos) begin
                  rec_nxt.e_trunc = 1'b1;
               end else begin
                  rec_nxt.hi       = f_imm;
                  rec_nxt.value    = c_value;
                  rec_nxt.e_pseudo = !f_low_zero;
               end
               state_nxt = ST_EMIT;
            end
         end
         ST_EMIT: begin
            if (out_ready) state_nxt = ST_IDLE;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         rec_q    <= '0;
         hold_dst <= '0;
         hold_sub <= '0;
         hold_lo  <= '0;
      end else begin
         state <= state_nxt;
         if (rec_load) rec_q <= rec_nxt;
         if (hold_load) begin
            hold_dst <= f_dst;
            hold_sub <= f_src;
            hold_lo  <= f_imm;
         end
      end
   end

   assign out_valid      = (state == ST_EMIT);
   assign out_kind       = rec_q.kind;
   assign out_slot       = rec_q.slot;
   assign out_dst        = rec_q.dst;
   assign out_sub        = rec_q.sub;
   assign out_imm_lo     = rec_q.lo;
   assign out_imm_hi     = rec_q.hi;
   assign out_value      = rec_q.value;
   assign out_err_pseudo = rec_q.e_pseudo;
   assign out_err_sub    = rec_q.e_sub;
   assign out_err_trunc  = rec_q.e_trunc;
endmodule

// File: rtl/wimm_assert_chk.sv
module wimm_assert_chk #(
   parameter int REG_W       = 4,
   parameter int IMM_W       = 32,
   parameter int SLOT_W      = 64,
   parameter int MAX_SUB     = 6,
   parameter bit ZERO_NONINT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_eos,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic               out_kind,
   input logic [SLOT_W-1:0]  out_slot,
   input logic [REG_W-1:0]   out_dst,
   input logic [REG_W-1:0]   out_sub,
   input logic [IMM_W-1:0]   out_imm_lo,
   input logic [IMM_W-1:0]   out_imm_hi,
   input logic [2*IMM_W-1:0] out_value,
   input logic               out_err_pseudo,
   input logic               out_err_sub,
   input logic               out_err_trunc
);
   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_slot) && $stable(out_value)
         && $stable(out_dst) && $stable(out_sub) && $stable(out_imm_lo)
         && $stable(out_imm_hi) && $stable(out_kind))); // R9

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> ($stable(out_err_pseudo) && $stable(out_err_sub)
         && $stable(out_err_trunc))); // R9

   AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_kind) |-> (!out_err_pseudo && !out_err_sub && !out_err_trunc
         && out_value == '0)); // R2

   AST_INT_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind && !out_err_trunc && out_sub == '0)
         |-> (out_value == {out_imm_hi, out_imm_lo})); // R4

   AST_NONINT_NO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_NONINT && out_valid && out_kind && out_sub != '0) |-> (out_value == '0)); // R5

   AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind) |-> (out_err_sub == (out_sub > REG_W'(MAX_SUB)))); // R7

   AST_TRUNC_EMPTY_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err_trunc) |-> (out_kind && out_imm_hi == '0 && out_value == '0
         && !out_err_pseudo)); // R8

   AST_MARKER_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && in_valid && in_ready && in_eos && $past(out_valid)) |=> !out_valid); // R8
endmodule

bind wide_imm_assembler wimm_assert_chk #(
   .REG_W(REG_W), .IMM_W(IMM_W), .SLOT_W(SLOT_W),
   .MAX_SUB(MAX_SUB), .ZERO_NONINT(ZERO_NONINT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eos(in_eos),
   .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
   .out_kind(out_kind), .out_slot(out_slot), .out_dst(out_dst), .out_sub(out_sub),
   .out_imm_lo(out_imm_lo), .out_imm_hi(out_imm_hi), .out_value(out_value),
   .out_err_pseudo(out_err_pseudo), .out_err_sub(out_err_sub),
   .out_err_trunc(out_err_trunc)
);

// File: tb/wide_imm_assembler_bench.sv
`timescale 1ns/1ps
module wide_imm_assembler_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] in_slot = '0;
   logic        in_eos = 1'b0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic        out_kind;
   logic [63:0] out_slot;
   logic [3:0]  out_dst, out_sub;
   logic [31:0] out_imm_lo, out_imm_hi;
   logic [63:0] out_value;
   logic        out_err_pseudo, out_err_sub, out_err_trunc;

   always #5 clk = ~clk;

   wide_imm_assembler u_wide_imm_assembler (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot), .in_eos(in_eos),
      .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
      .out_kind(out_kind), .out_slot(out_slot), .out_dst(out_dst), .out_sub(out_sub),
      .out_imm_lo(out_imm_lo), .out_imm_hi(out_imm_hi), .out_value(out_value),
      .out_err_pseudo(out_err_pseudo), .out_err_sub(out_err_sub),
      .out_err_trunc(out_err_trunc)
   );

   typedef struct {
      bit          kind;
      logic [63:0] slot;
      logic [3:0]  dst, sub;
      logic [31:0] lo, hi;
      logic [63:0] value;
      bit          ep, es, et;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   bp_en    = 1'b0;
   bit   done     = 1'b0;

   bit          m_have = 1'b0;
   logic [3:0]  m_dst, m_sub;
   logic [31:0] m_lo;

   function automatic string tag_of(exp_t e);
      if (e.et)            return "R8";
      if (e.ep)            return "R6";
      if (e.es)            return "R7";
      if (!e.kind)         return "R2";
      if (e.sub == 4'd0)   return "R4";
      return "R5";
   endfunction

   function automatic exp_t model_pair(logic [3:0] d, logic [3:0] s, logic [31:0] lo,
                                       logic [63:0] comp, bit trunc);
      exp_t e;
      e.kind = 1'b1; e.slot = '0; e.dst = d; e.sub = s; e.lo = lo;
      e.es = (s > 4'd6); e.et = trunc;
      e.hi = trunc ? 32'd0 : comp[63:32];
      e.ep = trunc ? 1'b0 : (comp[31:0] != 32'd0);
      e.value = (trunc || s != 4'd0) ? 64'd0 : {e.hi, lo};
      return e;
   endfunction

   function automatic exp_t model_pass(logic [63:0] s);
      exp_t e;
      e.kind = 1'b0; e.slot = s; e.dst = '0; e.sub = '0; e.lo = '0; e.hi = '0;
      e.value = '0; e.ep = 1'b0; e.es = 1'b0; e.et = 1'b0;
      return e;
   endfunction

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp_v);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_v);
      end
   endtask

   // beat driver: called at a point away from clock edges, returns 1 ns after acceptance
   task automatic push(logic [63:0] s, bit eos);
      in_valid = 1'b1; in_slot = s; in_eos = eos;
      while (!in_ready) begin @(posedge clk); #1; end
      @(posedge clk); #1;
      in_valid = 1'b0; in_eos = 1'b0;
      if (eos) begin
         if (m_have) q.push_back(model_pair(m_dst, m_sub, m_lo, 64'd0, 1'b1));
         m_have = 1'b0;
      end else if (m_have) begin
         q.push_back(model_pair(m_dst, m_sub, m_lo, s, 1'b0));
         m_have = 1'b0;
      end else if (s[7:0] == 8'h18) begin
         m_have = 1'b1; m_dst = s[11:8]; m_sub = s[15:12]; m_lo = s[63:32];
      end else begin
         q.push_back(model_pass(s));
      end
   endtask

   function automatic logic [63:0] wide_slot(logic [3:0] d, logic [3:0] s, logic [31:0] imm);
      return {imm, 16'h0000, s, d, 8'h18};
   endfunction

   // output monitor
   logic [63:0] snap_slot, snap_value;
   logic [31:0] snap_lo, snap_hi;
   bit          hold_pend = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend)
            check(out_valid && out_slot == snap_slot && out_value == snap_value
                  && out_imm_lo == snap_lo && out_imm_hi == snap_hi,
                  "R9", "stalled record changed", out_value, snap_value);
         if (out_valid && in_ready)
            check(1'b0, "R9", "ready while holding a record", 64'(in_ready), 64'd0);
         out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
         if (out_valid && out_ready) begin
            if (q.size() == 0) begin
               check(1'b0, "R8", "unexpected record", out_slot, 64'd0);
            end else begin
               exp_t e;
               bit ok;
               e = q.pop_front();
               ok = (out_kind == e.kind) && (out_slot == e.slot) && (out_dst == e.dst)
                    && (out_sub == e.sub) && (out_imm_lo == e.lo) && (out_imm_hi == e.hi)
                    && (out_value == e.value) && (out_err_pseudo == e.ep)
                    && (out_err_sub == e.es) && (out_err_trunc == e.et);
               check(ok, tag_of(e), "record mismatch (value/slot)",
                     e.kind ? out_value : out_slot, e.kind ? e.value : e.slot);
               if (!ok)
                  $display("      flags act p%0b s%0b t%0b exp p%0b s%0b t%0b hi act %h exp %h",
                           out_err_pseudo, out_err_sub, out_err_trunc, e.ep, e.es, e.et,
                           out_imm_hi, e.hi);
            end
         end
         hold_pend  = out_valid && !out_ready;
         snap_slot  = out_slot;  snap_value = out_value;
         snap_lo    = out_imm_lo; snap_hi   = out_imm_hi;
      end
   end

   task automatic drain();
      for (int k = 0; k < 200 && (q.size() != 0 || out_valid); k++) @(negedge clk);
      check(q.size() == 0, "R2", "records missing after drain", 64'(q.size()), 64'd0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual running expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks + 1, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready, "R1", "reset state valid/ready",
            {62'd0, out_valid, in_ready}, 64'd1);

      // R2 plain slots
      push(64'hDEAD_BEEF_0000_1261, 1'b0);
      push(64'h0000_0001_0000_0007, 1'b0);
      drain();

      // R3 first half held without output
      push(wide_slot(4'd3, 4'd0, 32'h89AB_CDEF), 1'b0);
      check(in_ready && !out_valid, "R3", "first half must not emit",
            {62'd0, out_valid, in_ready}, 64'd1);
      @(negedge clk); @(negedge clk);
      check(in_ready && !out_valid, "R3", "still waiting for companion",
            {62'd0, out_valid, in_ready}, 64'd1);
      // R4 join
      push({32'h0123_4567, 32'd0}, 1'b0);
      drain();

      // R5 offset-style subtypes
      push(wide_slot(4'd7, 4'd2, 32'h0000_1000), 1'b0);
      push({32'h0000_0040, 32'd0}, 1'b0);
      push(wide_slot(4'd1, 4'd6, 32'h0000_0005), 1'b0);
      push({32'hFFFF_FFF0, 32'd0}, 1'b0);
      drain();

      // R6 malformed companions, one field at a time
      push(wide_slot(4'd2, 4'd0, 32'h1111_1111), 1'b0);
      push({32'h2222_2222, 32'h0000_0001}, 1'b0);
      push(wide_slot(4'd2, 4'd0, 32'h1), 1'b0);
      push({32'h2, 32'h0000_0100}, 1'b0);
      push(wide_slot(4'd2, 4'd0, 32'h1), 1'b0);
      push({32'h2, 32'h0000_1000}, 1'b0);
      push(wide_slot(4'd2, 4'd0, 32'h1), 1'b0);
      push({32'h2, 32'h8000_0000}, 1'b0);
      // companion carrying the wide opcode is data, not a new pair
      push(wide_slot(4'd4, 4'd0, 32'h5), 1'b0);
      push({32'h6, 32'h0000_0018}, 1'b0);
      push(64'h0000_0000_0000_00B7, 1'b0);
      drain();

      // R7 subtype boundary
      push(wide_slot(4'd5, 4'd7, 32'hA), 1'b0);
      push({32'hB, 32'd0}, 1'b0);
      push(wide_slot(4'd5, 4'd15, 32'hA), 1'b0);
      push({32'hB, 32'd0}, 1'b0);
      drain();

      // R8 markers
      push(wide_slot(4'd9, 4'd0, 32'hCAFE_F00D), 1'b0);
      push(64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      drain();
      push(64'h0000_0000_0000_0018, 1'b1);
      repeat (3) @(negedge clk);
      check(!out_valid && in_ready, "R8", "idle marker must not emit",
            {62'd0, out_valid, in_ready}, 64'd1);
      push(64'h0000_0000_0000_0095, 1'b0);
      drain();

      // random mix with backpressure (R9 held under stall)
      bp_en = 1'b1;
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom % 100;
         if (r < 5) begin
            push({$urandom, $urandom}, 1'b1);
         end else if (r < 35) begin
            logic [3:0]  s;
            logic [63:0] comp;
            s = (($urandom % 5) == 0) ? 4'($urandom) : 4'($urandom % 7);
            push(wide_slot(4'($urandom), s, $urandom), 1'b0);
            comp = {$urandom, 32'd0};
            if (($urandom % 5) == 0) comp[31:0] = 32'd1 << ($urandom % 32);
            if (($urandom % 20) == 0) push(comp, 1'b1);
            else push(comp, 1'b0);
         end else begin
            logic [63:0] s;
            s = {$urandom, $urandom};
            if (s[7:0] == 8'h18) s[0] = 1'b1;
            push(s, 1'b0);
         end
      end
      bp_en = 1'b0;
      if (m_have) push(64'd0, 1'b1);
      drain();

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule